// File: doc/BRIEF.md
# Over-Temperature Protection Comparator

This block watches the raw codes produced by four temperature sensing points and raises a protection interrupt once the watched reading reaches a programmed raw limit. Raw codes run opposite to temperature: the code falls as the die heats, so a hotter point gives a smaller code. Because of this, the trip test is "reading at or below the limit", and the hottest of several points is the one with the smallest code.

A 4-bit source code picks what is watched. It can pick one sensing point, or it can pick the hottest of the four, using the latest code that each point has reported. A 14-bit cold offset is added to every reading before the comparison. The sum saturates at the largest raw code and does not wrap. Software raises the offset to make every reading look cold while it reprograms the limit. A reading of zero means no sample and never counts. A trip sets a sticky status bit that stays set until a write-one-to-clear pulse. The interrupt line is that status gated by an enable bit.

Software loads the limit as the raw code of the trip temperature. The code is found by inverting millidegrees = ((a * raw) >> 14) + golden * 500 + b, where a is negative. That conversion lives in software and is not part of the block.

Top module: `ovtemp_guard`

## Requirements
- R1: After synchronous reset, `prot_sts` and `prot_irq` are 0 and every point's stored reading is zero, so the hottest mode sees no valid point.
- R2: Source code 2, 6, 10 or 14, which is (index << 2) + 2, watches sensing point 0, 1, 2 or 3. A trip occurs in a cycle where that point's strobe is high and its adjusted code is at or below `trip_thr`.
- R3: The comparison is inclusive. An adjusted code equal to `trip_thr` trips, and `trip_thr` + 1 does not.
- R4: Source code 1 watches the hottest point. In any cycle with at least one strobe high, the block takes, for each point, this cycle's code if strobed or else its last strobed code. It trips if the smallest adjusted value among the points whose code is nonzero is at or below `trip_thr`.
- R5: `cold_offset` is added to each raw code before the comparison. The sum saturates at all ones (2^RAW_W - 1) and does not wrap.
- R6: A raw code of zero never trips. In the hottest mode a point whose code is zero is left out of the minimum.
- R7: Any source code other than 1, 2, 6, 10 or 14 disables protection, and no trip occurs.
- R8: `prot_sts` is set by a trip and stays set until a cycle where `sts_clr` is high and no trip occurs. When a trip and a clear fall in the same cycle, the trip wins.
- R9: `prot_irq` is high exactly when `prot_sts` and `prot_ie` are both high. `prot_ie` has no effect on `prot_sts`.
- R10: In single-point mode, strobes on points other than the watched one never trip.
- R11: A trip shows on `prot_sts` right after the clock edge that samples the strobe. No trip occurs in a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_raw | input | 4 x RAW_W | Raw code of each sensing point |
| smp_vld | input | 4 | Per-point strobe marking a new code |
| trip_thr | input | RAW_W | Raw trip limit |
| src_code | input | 4 | Source selection code |
| cold_offset | input | 14 | Offset added to each reading |
| prot_ie | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status |
| prot_irq | output | 1 | Level protection interrupt |
| prot_sts | output | 1 | Sticky protection status |

## Verification
Every one of the sixteen source codes is driven against every sensing point, with codes of zero, one below, equal to and one above the limit. A design that compares the wrong way round, uses a strict compare, decodes the point index from the wrong bits or lets a stray code enable protection produces a mismatch in this sweep. The hottest mode is run with one cold point and one hot point that was strobed earlier. This catches a design that forgets earlier codes or takes a zero code as the hottest. An offset that drives the sum past the top of the range separates saturation from wrap-around, because a wrapped sum looks hot and trips. A clear that arrives in the same cycle as a trip checks that the status cannot be lost.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int NPTS    = 4;
    localparam int IDX_W   = $clog2(NPTS);
    localparam int CODE_W  = 4;
    localparam int OFS_W   = 14;

    localparam logic [CODE_W-1:0] CODE_HOTTEST = 4'd1;
    localparam logic [1:0]        CODE_ONE_TAG = 2'b10;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_ONE = 2'd1,
        SRC_HOT = 2'd2
    } src_mode_e;

    typedef struct packed {
        src_mode_e         mode;
        logic [IDX_W-1:0]  idx;
    } src_sel_t;

    // Code 1 picks the hottest point; (index << 2) + 2 picks one point.
    function automatic src_sel_t decode_src(input logic [CODE_W-1:0] code);
        src_sel_t s;
        s.mode = SRC_OFF;
        s.idx  = '0;
        if (code == CODE_HOTTEST) begin
            s.mode = SRC_HOT;
        end else if (code[1:0] == CODE_ONE_TAG) begin
            s.mode = SRC_ONE;
            s.idx  = code[3:2];
        end
        return s;
    endfunction

endpackage

// File: rtl/otp_hold.sv
module otp_hold
    import otp_pkg::*;
#(
    parameter int RAW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [RAW_W-1:0] raw,
    input  logic [OFS_W-1:0] ofs,
    output logic             cur_ok,
    output logic [RAW_W-1:0] cur_adj
);
    localparam logic [RAW_W-1:0] RAW_MAX = {RAW_W{1'b1}};

    logic [RAW_W-1:0] held_q;
    logic [RAW_W-1:0] merged;
    logic [RAW_W:0]   sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (vld) begin
            held_q <= raw;
        end
    end

    always_comb begin
        merged  = vld ? raw : held_q;
        sum     = {1'b0, merged} + {{(RAW_W + 1 - OFS_W){1'b0}}, ofs};
        cur_adj = sum[RAW_W] ? RAW_MAX : sum[RAW_W-1:0];
        cur_ok  = (merged != '0);
    end

endmodule

// File: rtl/otp_select.sv
module otp_select
    import otp_pkg::*;
#(
    parameter int RAW_W = 16
) (
    input  src_sel_t                     sel,
    input  logic [NPTS-1:0]              vld,
    input  logic [NPTS-1:0]              ok,
    input  logic [NPTS-1:0][RAW_W-1:0]   adj,
    output logic                         cand_vld,
    output logic [RAW_W-1:0]             cand
);
    logic             any_ok;
    logic [RAW_W-1:0] min_val;

    always_comb begin
        any_ok  = 1'b0;
        min_val = {RAW_W{1'b1}};
        for (int i = 0; i < NPTS; i++) begin
            if (ok[i] && (!any_ok || adj[i] < min_val)) begin
                min_val = adj[i];
                any_ok  = 1'b1;
            end
        end
    end

    always_comb begin
        cand_vld = 1'b0;
        cand     = adj[sel.idx];
        unique case (sel.mode)
            SRC_ONE: cand_vld = vld[sel.idx] && ok[sel.idx];
            SRC_HOT: begin
                cand_vld = (|vld) && any_ok;
                cand     = min_val;
            end
            default: cand_vld = 1'b0;
        endcase
    end

endmodule

// File: rtl/otp_flag.sv
module otp_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic ie,
    output logic sts,
    output logic irq
);
    logic sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
        end else begin
            sts_q <= hit | (sts_q & ~clr);
        end
    end

    assign sts = sts_q;
    assign irq = sts_q & ie;

endmodule

// File: rtl/ovtemp_guard.sv
module ovtemp_guard
    import otp_pkg::*;
#(
    parameter int RAW_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [3:0][RAW_W-1:0]       smp_raw,
    input  logic [3:0]                  smp_vld,
    input  logic [RAW_W-1:0]            trip_thr,
    input  logic [3:0]                  src_code,
    input  logic [13:0]                 cold_offset,
    input  logic                        prot_ie,
    input  logic                        sts_clr,
    output logic                        prot_irq,
    output logic                        prot_sts
);
    src_sel_t                    sel;
    logic [NPTS-1:0]             pt_ok;
    logic [NPTS-1:0][RAW_W-1:0]  pt_adj;
    logic                        cand_vld;
    logic [RAW_W-1:0]            cand;
    logic                        hit;

    assign sel = decode_src(src_code);

    for (genvar g = 0; g < NPTS; g++) begin : g_pt
        otp_hold #(.RAW_W(RAW_W)) u_hold (
            .clk     (clk),
            .rst     (rst),
            .vld     (smp_vld[g]),
            .raw     (smp_raw[g]),
            .ofs     (cold_offset),
            .cur_ok  (pt_ok[g]),
            .cur_adj (pt_adj[g])
        );
    end

    otp_select #(.RAW_W(RAW_W)) u_sel (
        .sel      (sel),
        .vld      (smp_vld),
        .ok       (pt_ok),
        .adj      (pt_adj),
        .cand_vld (cand_vld),
        .cand     (cand)
    );

    assign hit = cand_vld && (cand <= trip_thr);

    otp_flag u_flag (
        .clk (clk),
        .rst (rst),
        .hit (hit),
        .clr (sts_clr),
        .ie  (prot_ie),
        .sts (prot_sts),
        .irq (prot_irq)
    );

endmodule

// File: rtl/ovtemp_guard_chk.sv
module ovtemp_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] smp_vld,
    input logic [3:0] src_code,
    input logic       prot_ie,
    input logic       sts_clr,
    input logic       prot_irq,
    input logic       prot_sts
);
    logic code_live;
    assign code_live = (src_code == 4'd1) || (src_code[1:0] == 2'b10);

    // R1
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !prot_sts);

    // R7
    a_r7_dead_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (!code_live && !prot_sts) |=> !prot_sts);

    // R8
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (prot_sts && !sts_clr) |=> prot_sts);

    // R9
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        prot_irq |-> (prot_ie && prot_sts));

    // R11
    a_r11_rise_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_sts) |-> $past(|smp_vld));

endmodule

bind ovtemp_guard ovtemp_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .src_code (src_code),
    .prot_ie  (prot_ie),
    .sts_clr  (sts_clr),
    .prot_irq (prot_irq),
    .prot_sts (prot_sts)
);

// File: tb/ovtemp_guard_test.sv
`timescale 1ns/1ps
module ovtemp_guard_test;
    localparam int W = 16;
    localparam int MAXV = (1 << W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [3:0][W-1:0]  smp_raw = '0;
    logic [3:0]         smp_vld = '0;
    logic [W-1:0]       trip_thr = '0;
    logic [3:0]         src_code = '0;
    logic [13:0]        cold_offset = '0;
    logic               prot_ie = 1'b0;
    logic               sts_clr = 1'b0;
    logic               prot_irq;
    logic               prot_sts;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    int  mh [4];
    logic exp_sts = 1'b0;

    always #2 clk = ~clk;

    ovtemp_guard #(.RAW_W(W)) uut (
        .clk(clk), .rst(rst), .smp_raw(smp_raw), .smp_vld(smp_vld),
        .trip_thr(trip_thr), .src_code(src_code), .cold_offset(cold_offset),
        .prot_ie(prot_ie), .sts_clr(sts_clr), .prot_irq(prot_irq), .prot_sts(prot_sts)
    );

    function automatic int adj_of(input int v);
        int s;
        s = v + int'(cold_offset);
        return (s > MAXV) ? MAXV : s;
    endfunction

    function automatic logic model_trip();
        int  m [4];
        int  best;
        logic have;
        logic t;
        for (int i = 0; i < 4; i++) m[i] = smp_vld[i] ? int'(smp_raw[i]) : mh[i];
        t = 1'b0;
        if (src_code == 4'd1) begin
            have = 1'b0;
            best = 0;
            for (int i = 0; i < 4; i++)
                if (m[i] != 0 && (!have || adj_of(m[i]) < best)) begin
                    best = adj_of(m[i]);
                    have = 1'b1;
                end
            t = (smp_vld != 4'd0) && have && (best <= int'(trip_thr));
        end else if (src_code[1:0] == 2'b10) begin
            int k;
            k = int'(src_code[3:2]);
            t = smp_vld[k] && (m[k] != 0) && (adj_of(m[k]) <= int'(trip_thr));
        end
        return t;
    endfunction

    task automatic cyc(input string tag);
        logic t;
        t = model_trip();
        exp_sts = t | (exp_sts & ~sts_clr);
        for (int i = 0; i < 4; i++) if (smp_vld[i]) mh[i] = int'(smp_raw[i]);
        @(negedge clk);
        checks++;
        if (prot_sts !== exp_sts || prot_irq !== (exp_sts & prot_ie)) begin
            fails++;
            $display("FAIL %s: sts=%b irq=%b expected sts=%b irq=%b (code=%0d vld=%b)",
                     tag, prot_sts, prot_irq, exp_sts, exp_sts & prot_ie, src_code, smp_vld);
        end
        smp_vld = '0;
        sts_clr = 1'b0;
    endtask

    task automatic clear_all();
        sts_clr = 1'b1;
        cyc("R8 clear");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mh[i] = 0;
        prot_ie = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (prot_sts !== 1'b0 || prot_irq !== 1'b0) begin
            fails++;
            $display("FAIL R1: sts=%b irq=%b expected 0 0", prot_sts, prot_irq);
        end
        // R1: hottest mode with no stored readings and a zero strobe
        trip_thr = 16'hFFFF;
        src_code = 4'd1;
        smp_vld = 4'b0001; smp_raw[0] = '0;
        cyc("R1 R6 empty hottest");

        // R2 R3 R6 R7 R10: sweep every code, point and boundary value
        trip_thr = 16'h0400;
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 5; v++) begin
                    int rv;
                    case (v)
                        0: rv = 0;
                        1: rv = 16'h03FF;
                        2: rv = 16'h0400;
                        3: rv = 16'h0401;
                        default: rv = 16'hC000;
                    endcase
                    clear_all();
                    src_code = 4'(c);
                    smp_vld = 4'(1 << p);
                    smp_raw[p] = W'(rv);
                    prot_ie = v[0];
                    cyc("R2 R3 R6 R7 R9 R10 sweep");
                end
            end
        end
        prot_ie = 1'b1;

        // R4 R6: hottest mode, retention and zero exclusion
        src_code = 4'd1;
        for (int k = 0; k < 4; k++) begin
            clear_all();
            smp_vld = 4'hF;
            for (int i = 0; i < 4; i++) smp_raw[i] = 16'h8000;
            cyc("R4 all cold");
            smp_vld = 4'(1 << k); smp_raw[k] = 16'h0300;
            cyc("R4 one hot");
            clear_all();
            smp_vld = 4'(1 << ((k + 1) % 4)); smp_raw[(k + 1) % 4] = 16'h9000;
            cyc("R4 retained hot point");
            clear_all();
            smp_vld = 4'(1 << k); smp_raw[k] = '0;
            cyc("R6 zero excluded");
            smp_vld = 4'(1 << ((k + 2) % 4)); smp_raw[(k + 2) % 4] = 16'h9000;
            cyc("R6 zero stays excluded");
        end

        // R5: offset masks a hot reading, and saturation
        clear_all();
        src_code = 4'd6;
        cold_offset = 14'h3FFF;
        smp_vld = 4'b0010; smp_raw[1] = 16'h0100;
        cyc("R5 offset masks");
        trip_thr = 16'hFFFE;
        smp_vld = 4'b0010; smp_raw[1] = 16'hF000;
        cyc("R5 saturate no wrap");
        trip_thr = 16'hFFFF;
        smp_vld = 4'b0010; smp_raw[1] = 16'hF000;
        cyc("R5 saturate equals max");
        clear_all();
        cold_offset = 14'h0010;
        trip_thr = 16'h0400;
        smp_vld = 4'b0010; smp_raw[1] = 16'h03F0;
        cyc("R5 offset edge equal");
        clear_all();
        smp_vld = 4'b0010; smp_raw[1] = 16'h03F1;
        cyc("R5 offset edge over");
        cold_offset = '0;

        // R8 R9 R11: sticky, trip beats clear, enable gating, no strobe
        clear_all();
        src_code = 4'd14;
        smp_vld = 4'b1000; smp_raw[3] = 16'h0010;
        cyc("R11 trip next edge");
        prot_ie = 1'b0;
        cyc("R9 disabled irq");
        prot_ie = 1'b1;
        cyc("R8 stays set");
        smp_vld = 4'b1000; smp_raw[3] = 16'h0010; sts_clr = 1'b1;
        cyc("R8 trip wins over clear");
        clear_all();
        smp_raw[3] = 16'h0010;
        cyc("R11 no strobe no trip");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule